// File: doc/BRIEF.md
# Sleep Wake-Up Controller

This block decides when a small processor's main clock may stop and when it may start again. Software selects a low-power mode on a two-bit field and issues a sleep strobe. From then on the block watches a set of wake sources and keeps the main clock stopped. The sources are an external reset request, a watchdog reset, an external level interrupt, and two timer events. Once a wake is accepted, the block holds the clock stopped for a configurable oscillator start-up time. It then lets execution resume.

A deeper power-down mode listens only to resets and the level interrupt. The level interrupt is qualified on a slow sampling enable so that short noise cannot wake the part. A power-save mode adds the overflow and compare events of a timer, but only when that timer runs from its own asynchronous clock. After a power-save wake, the interrupt-flag update for the waking source is held back by a fixed number of instruction cycles. One instruction cycle equals one clock cycle here. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `slp_wake_ctrl`

## Requirements
- R1: A sleep strobe is ignored when the mode field is 2'b00 or 2'b01. `cpu_run` stays high and `clk_stop` stays low.
- R2: While running, a sleep strobe with mode 2'b10 (power-down) or 2'b11 (power-save) raises `clk_stop` and drops `cpu_run` in the next cycle.
- R3: While asleep in either mode, `ext_rst_wake` wakes the block without qualification. So does `wdt_rst` while `wdt_en` is high. A `wdt_rst` with `wdt_en` low is ignored.
- R4: A level wake needs `ext_irq_lvl` high on two successive cycles in which `slow_tick` is high. A high sample followed by a low sample at the next tick leaves the block asleep.
- R5: Let D = max(`startup_len`, 1). `cpu_run` rises D+1 cycles after the cycle in which the wake is presented.
- R6: If `ext_irq_lvl` is low in any cycle of the start-up delay of a level wake, no interrupt-flag strobe is produced. Execution still resumes.
- R7: A level wake from power-down pulses `ext_flag_stb` once, in the first cycle with `cpu_run` high.
- R8: A level wake from power-save pulses `ext_flag_stb` once, in the third cycle with `cpu_run` high, so two instruction cycles run first.
- R9: In power-save, a timer overflow or compare event wakes the block if `tmr_async` was high at sleep entry and that event's enable is high. `tmr_flag_stb` then pulses once, in the fourth cycle with `cpu_run` high.
- R10: A timer event is ignored if its enable is low, if `tmr_async` was low at sleep entry, or in power-down.
- R11: A reset wake presented in the same cycle as another wake wins. It produces no flag strobe.
- R12: `tmr_state_valid` is high after reset. It drops when execution resumes from a power-save sleep entered with `tmr_async` low, unless the wake was a reset. Any reset wake raises it again. It changes only in the cycle where `clk_stop` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| mode_sel | input | 2 | Sleep mode select: 10 power-down, 11 power-save, others idle |
| sleep_req | input | 1 | Sleep instruction strobe |
| startup_len | input | 8 | Start-up delay in cycles (0 treated as 1) |
| ext_rst_wake | input | 1 | External reset request |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_rst | input | 1 | Watchdog reset request |
| ext_irq_lvl | input | 1 | External interrupt level, active high |
| slow_tick | input | 1 | One-cycle enable at the slow sampling rate |
| tmr_async | input | 1 | Timer runs from its asynchronous clock |
| tmr_ovf_evt | input | 1 | Timer overflow event |
| tmr_ovf_en | input | 1 | Overflow interrupt enable |
| tmr_cmp_evt | input | 1 | Timer compare event |
| tmr_cmp_en | input | 1 | Compare interrupt enable |
| clk_stop | output | 1 | Main clock gated off |
| cpu_run | output | 1 | Processor may execute |
| ext_flag_stb | output | 1 | One-cycle external interrupt flag update |
| tmr_flag_stb | output | 1 | One-cycle timer interrupt flag update |
| tmr_state_valid | output | 1 | Timer register contents are defined |

## Verification
A corrupted delay counter shows at the ports as `cpu_run` rising early or late against D+1. A corrupted deferral shows as a flag strobe off its fixed run-cycle slot. Either fault is visible within ten cycles of the wake. A wrong qualifier or source-priority state shows as a wake that should not occur, or as a stray strobe. The stray strobe appears in the same resume window. A wrong timer-validity state persists on `tmr_state_valid` until the next reset wake, so it can be caught at any later sample.

// File: rtl/slp_wake_pkg.sv
package slp_wake_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_START, ST_DEFER} slp_state_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_RST, SRC_EXT, SRC_TMR} wake_src_e;
  localparam logic [1:0] MODE_PDOWN = 2'b10;
  localparam logic [1:0] MODE_PSAVE = 2'b11;
endpackage

// File: rtl/slp_lvl_qual.sv
// Counts consecutive high samples of a level taken on slow ticks while armed.
module slp_lvl_qual #(
  parameter int unsigned NEED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic lvl,
  input  logic tick,
  output logic hit
);
  localparam int unsigned CW = $clog2(NEED + 1);
  localparam logic [CW-1:0] LAST = CW'(NEED - 1);
  localparam logic [CW-1:0] FULL = CW'(NEED);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!arm) begin
      run_q <= '0;
    end else if (tick) begin
      if (!lvl)              run_q <= '0;
      else if (run_q != FULL) run_q <= run_q + 1'b1;
    end
  end

  assign hit = arm && tick && lvl && (run_q >= LAST);
endmodule

// File: rtl/slp_dly_cnt.sv
// Loadable down-counter; 'last' flags the final cycle of a phase.
module slp_dly_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q > ONE) cnt_q <= cnt_q - ONE;
  end

  assign last = (cnt_q <= ONE);
endmodule

// File: rtl/slp_wake_arb.sv
// Wake source decode and priority: reset, then level, then timer events.
module slp_wake_arb
  import slp_wake_pkg::*;
#(
  parameter int unsigned NTMR = 2
) (
  input  logic            ext_rst,
  input  logic            wdt_en,
  input  logic            wdt_rst,
  input  logic            lvl_hit,
  input  logic            psave,
  input  logic            async_on,
  input  logic [NTMR-1:0] tmr_evt,
  input  logic [NTMR-1:0] tmr_en,
  output logic            rst_hit,
  output wake_src_e       src
);
  logic [NTMR-1:0] tmr_live;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    assign tmr_live[g] = tmr_evt[g] && tmr_en[g];
  end

  assign rst_hit = ext_rst || (wdt_en && wdt_rst);

  always_comb begin
    if (rst_hit)                           src = SRC_RST;
    else if (lvl_hit)                      src = SRC_EXT;
    else if (psave && async_on && |tmr_live) src = SRC_TMR;
    else                                   src = SRC_NONE;
  end
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
  import slp_wake_pkg::*;
#(
  parameter int unsigned DLY_W     = 8,
  parameter int unsigned QUAL_N    = 2,
  parameter int unsigned EXT_DEFER = 2,
  parameter int unsigned TMR_DEFER = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             sleep_req,
  input  logic [DLY_W-1:0] startup_len,
  input  logic             ext_rst_wake,
  input  logic             wdt_en,
  input  logic             wdt_rst,
  input  logic             ext_irq_lvl,
  input  logic             slow_tick,
  input  logic             tmr_async,
  input  logic             tmr_ovf_evt,
  input  logic             tmr_ovf_en,
  input  logic             tmr_cmp_evt,
  input  logic             tmr_cmp_en,
  output logic             clk_stop,
  output logic             cpu_run,
  output logic             ext_flag_stb,
  output logic             tmr_flag_stb,
  output logic             tmr_state_valid
);
  localparam int unsigned DEF_MAX = (EXT_DEFER > TMR_DEFER) ? EXT_DEFER : TMR_DEFER;
  localparam int unsigned DEF_W   = $clog2(DEF_MAX + 1);
  localparam int unsigned CNT_W   = (DLY_W > DEF_W) ? DLY_W : DEF_W;

  slp_state_e state_q;
  wake_src_e  src_q, arb_src, eff_src;
  logic save_q, async_q, cancel_q, ext_stb_q, tmr_stb_q, valid_q;
  logic lvl_hit, rst_hit, cnt_last, cnt_load, drop, flag_ok, go_tmr, go_defer;
  logic [CNT_W-1:0] cnt_val, defer_val;

  slp_lvl_qual #(.NEED(QUAL_N)) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (state_q == ST_SLEEP),
    .lvl  (ext_irq_lvl),
    .tick (slow_tick),
    .hit  (lvl_hit)
  );

  slp_wake_arb #(.NTMR(2)) u_arb (
    .ext_rst (ext_rst_wake),
    .wdt_en  (wdt_en),
    .wdt_rst (wdt_rst),
    .lvl_hit (lvl_hit),
    .psave   (save_q),
    .async_on(async_q),
    .tmr_evt ({tmr_cmp_evt, tmr_ovf_evt}),
    .tmr_en  ({tmr_cmp_en, tmr_ovf_en}),
    .rst_hit (rst_hit),
    .src     (arb_src)
  );

  slp_dly_cnt #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(cnt_val),
    .last    (cnt_last)
  );

  always_comb begin
    eff_src   = rst_hit ? SRC_RST : src_q;
    drop      = (src_q == SRC_EXT) && !ext_irq_lvl;
    flag_ok   = (eff_src == SRC_EXT) && !cancel_q && !drop;
    go_tmr    = (eff_src == SRC_TMR);
    go_defer  = save_q && (go_tmr || flag_ok);
    defer_val = go_tmr ? CNT_W'(TMR_DEFER) : CNT_W'(EXT_DEFER);
    cnt_load  = 1'b0;
    cnt_val   = defer_val;
    if (state_q == ST_SLEEP && arb_src != SRC_NONE) begin
      cnt_load = 1'b1;
      cnt_val  = CNT_W'(startup_len);
    end else if (state_q == ST_START && cnt_last && go_defer) begin
      cnt_load = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      src_q     <= SRC_NONE;
      save_q    <= 1'b0;
      async_q   <= 1'b0;
      cancel_q  <= 1'b0;
      ext_stb_q <= 1'b0;
      tmr_stb_q <= 1'b0;
      valid_q   <= 1'b1;
    end else begin
      ext_stb_q <= 1'b0;
      tmr_stb_q <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          if (sleep_req && (mode_sel == MODE_PDOWN || mode_sel == MODE_PSAVE)) begin
            state_q <= ST_SLEEP;
            save_q  <= (mode_sel == MODE_PSAVE);
            async_q <= tmr_async;
          end
        end
        ST_SLEEP: begin
          if (arb_src != SRC_NONE) begin
            state_q  <= ST_START;
            src_q    <= arb_src;
            cancel_q <= 1'b0;
          end
        end
        ST_START: begin
          if (rst_hit) src_q <= SRC_RST;
          if (drop)    cancel_q <= 1'b1;
          if (cnt_last) begin
            if (eff_src == SRC_RST)   valid_q <= 1'b1;
            else if (save_q && !async_q) valid_q <= 1'b0;
            if (go_defer) begin
              state_q <= ST_DEFER;
            end else begin
              state_q   <= ST_RUN;
              ext_stb_q <= flag_ok;
            end
          end
        end
        ST_DEFER: begin
          if (cnt_last) begin
            state_q <= ST_RUN;
            if (src_q == SRC_TMR) tmr_stb_q <= 1'b1;
            else                  ext_stb_q <= 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign clk_stop        = (state_q == ST_SLEEP) || (state_q == ST_START);
  assign cpu_run         = !clk_stop;
  assign ext_flag_stb    = ext_stb_q;
  assign tmr_flag_stb    = tmr_stb_q;
  assign tmr_state_valid = valid_q;
endmodule

// File: rtl/slp_wake_ctrl_chk.sv
module slp_wake_ctrl_chk #(
  parameter int unsigned EXT_DEFER = 2,
  parameter int unsigned TMR_DEFER = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       sleep_req,
  input logic       clk_stop,
  input logic       cpu_run,
  input logic       ext_flag_stb,
  input logic       tmr_flag_stb,
  input logic       tmr_state_valid
);
  localparam int unsigned SAT = ((EXT_DEFER > TMR_DEFER) ? EXT_DEFER : TMR_DEFER) + 1;
  localparam int unsigned RW  = $clog2(SAT + 1);
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_cnt <= RW'(SAT);
    else if (clk_stop)            run_cnt <= '0;
    else if (run_cnt != RW'(SAT)) run_cnt <= run_cnt + 1'b1;
  end

  // R1
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run && sleep_req && !mode_sel[1] |=> cpu_run);

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_stop) |-> $past(sleep_req && mode_sel[1] && cpu_run));

  // R7 R8
  ext_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_flag_stb |-> cpu_run && (run_cnt == '0 || run_cnt == RW'(EXT_DEFER)));

  // R9
  tmr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_flag_stb |-> cpu_run && run_cnt == RW'(TMR_DEFER));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_flag_stb, tmr_flag_stb}));

  // R12
  valid_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tmr_state_valid) |-> $fell(clk_stop));
endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk #(
  .EXT_DEFER(EXT_DEFER),
  .TMR_DEFER(TMR_DEFER)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_sel       (mode_sel),
  .sleep_req      (sleep_req),
  .clk_stop       (clk_stop),
  .cpu_run        (cpu_run),
  .ext_flag_stb   (ext_flag_stb),
  .tmr_flag_stb   (tmr_flag_stb),
  .tmr_state_valid(tmr_state_valid)
);

// File: tb/test_slp_wake_ctrl.sv
`timescale 1ns/1ps
module test_slp_wake_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic sleep_req = 1'b0;
  logic [7:0] startup_len = 8'd0;
  logic ext_rst_wake = 1'b0, wdt_en = 1'b0, wdt_rst = 1'b0;
  logic ext_irq_lvl = 1'b0, slow_tick = 1'b0, tmr_async = 1'b0;
  logic tmr_ovf_evt = 1'b0, tmr_ovf_en = 1'b0, tmr_cmp_evt = 1'b0, tmr_cmp_en = 1'b0;
  logic clk_stop, cpu_run, ext_flag_stb, tmr_flag_stb, tmr_state_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int exp_valid = 1;

  always #5 clk = ~clk;

  slp_wake_ctrl i_slp_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_req(sleep_req),
    .startup_len(startup_len), .ext_rst_wake(ext_rst_wake), .wdt_en(wdt_en),
    .wdt_rst(wdt_rst), .ext_irq_lvl(ext_irq_lvl), .slow_tick(slow_tick),
    .tmr_async(tmr_async), .tmr_ovf_evt(tmr_ovf_evt), .tmr_ovf_en(tmr_ovf_en),
    .tmr_cmp_evt(tmr_cmp_evt), .tmr_cmp_en(tmr_cmp_en), .clk_stop(clk_stop),
    .cpu_run(cpu_run), .ext_flag_stb(ext_flag_stb), .tmr_flag_stb(tmr_flag_stb),
    .tmr_state_valid(tmr_state_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dly(input int len);
    return (len < 1) ? 1 : len;
  endfunction

  // Run-cycle index (1 = first cycle after the wake edge) of each expected event.
  function automatic int exp_ext_at(input int mode, input int src, input int len, input int cancel);
    if (src != 2 || cancel != 0) return -1;
    return (mode == 2) ? dly(len) + 1 : dly(len) + 3;
  endfunction

  function automatic int exp_tmr_at(input int src, input int len);
    return (src == 3 || src == 4) ? dly(len) + 4 : -1;
  endfunction

  task automatic enter(input int mode, input int asy, input int len);
    @(negedge clk);
    startup_len = 8'(len); tmr_async = asy[0]; mode_sel = 2'(mode); sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R2 clk_stop after sleep", int'(clk_stop), 1);
    chk("R2 cpu_run after sleep", int'(cpu_run), 0);
  endtask

  task automatic recover();
    @(negedge clk);
    ext_rst_wake = 1'b1;
    @(negedge clk);
    ext_rst_wake = 1'b0;
    repeat (12) @(negedge clk);
    exp_valid = 1;
    chk("R3 reset wake resumes", int'(cpu_run), 1);
  endtask

  // src: 0 ext reset, 1 watchdog, 2 level, 3 overflow, 4 compare, 5 level+reset same cycle
  task automatic run_case(input int mode, input int src, input int len, input int cancel, input int asy);
    int run_at = -1, ext_at = -1, tmr_at = -1, ext_n = 0, tmr_n = 0;
    enter(mode, asy, len);
    @(negedge clk);
    case (src)
      0: ext_rst_wake = 1'b1;
      1: begin wdt_en = 1'b1; wdt_rst = 1'b1; end
      2, 5: begin
        ext_irq_lvl = 1'b1; slow_tick = 1'b1;
        @(negedge clk); slow_tick = 1'b0;
        @(negedge clk); slow_tick = 1'b1;
        if (src == 5) ext_rst_wake = 1'b1;
      end
      3: begin tmr_ovf_evt = 1'b1; tmr_ovf_en = 1'b1; end
      default: begin tmr_cmp_evt = 1'b1; tmr_cmp_en = 1'b1; end
    endcase
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (cpu_run && run_at < 0) run_at = k;
      if (ext_flag_stb) begin ext_at = k; ext_n++; end
      if (tmr_flag_stb) begin tmr_at = k; tmr_n++; end
      if (k == 1) begin
        slow_tick = 1'b0; ext_rst_wake = 1'b0; wdt_rst = 1'b0;
        tmr_ovf_evt = 1'b0; tmr_cmp_evt = 1'b0;
        if (cancel != 0 && src == 2) ext_irq_lvl = 1'b0;
      end
    end
    ext_irq_lvl = 1'b0; wdt_en = 1'b0; tmr_ovf_en = 1'b0; tmr_cmp_en = 1'b0;
    if (src <= 1 || src == 5) exp_valid = 1;
    else if (mode == 3 && asy == 0) exp_valid = 0;
    chk("R5 resume cycle", run_at, dly(len) + 1);
    if (src == 5) chk("R11 reset priority no ext flag", ext_n, 0);
    else if (src == 2 && cancel != 0) chk("R6 cancelled flag", ext_n, 0);
    else if (src == 2 && mode == 2) chk("R7 power-down ext flag slot", ext_at, exp_ext_at(mode, src, len, cancel));
    else if (src == 2) chk("R8 power-save ext flag slot", ext_at, exp_ext_at(mode, src, len, cancel));
    else if (src <= 1) chk("R3 reset wake no ext flag", ext_n, 0);
    if (src == 3 || src == 4) chk("R9 timer flag slot", tmr_at, exp_tmr_at(src, len));
    chk("R8 R9 single strobe", ext_n + tmr_n, (exp_ext_at(mode, src, len, cancel) > 0 || src == 3 || src == 4) ? 1 : 0);
    chk("R12 timer state valid", int'(tmr_state_valid), exp_valid);
  endtask

  task automatic hold_asleep(input string req);
    repeat (4) @(negedge clk);
    chk(req, int'(clk_stop), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset cpu_run", int'(cpu_run), 1);
    chk("reset clk_stop", int'(clk_stop), 0);
    chk("reset strobes", int'(ext_flag_stb) + int'(tmr_flag_stb), 0);
    chk("R12 reset valid", int'(tmr_state_valid), 1);

    // R1: idle-type modes
    for (int m = 0; m < 2; m++) begin
      mode_sel = 2'(m); sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      chk("R1 idle mode keeps running", int'(cpu_run), 1);
      chk("R1 idle mode clock on", int'(clk_stop), 0);
    end

    // R4: glitch of a single tick
    enter(2, 0, 3);
    ext_irq_lvl = 1'b1; slow_tick = 1'b1;
    @(negedge clk); slow_tick = 1'b0;
    @(negedge clk); ext_irq_lvl = 1'b0; slow_tick = 1'b1;
    @(negedge clk); slow_tick = 1'b0;
    hold_asleep("R4 single-tick glitch ignored");
    // R3: watchdog reset while watchdog disabled
    wdt_rst = 1'b1;
    @(negedge clk); wdt_rst = 1'b0;
    hold_asleep("R3 disabled watchdog ignored");
    recover();

    // R10: timer event cases that must not wake
    enter(3, 1, 2);
    tmr_ovf_evt = 1'b1;
    @(negedge clk); tmr_ovf_evt = 1'b0;
    hold_asleep("R10 overflow with enable clear");
    recover();
    enter(3, 0, 2);
    tmr_cmp_evt = 1'b1; tmr_cmp_en = 1'b1;
    @(negedge clk); tmr_cmp_evt = 1'b0;
    hold_asleep("R10 compare with async clear");
    recover();
    enter(2, 1, 2);
    tmr_ovf_evt = 1'b1; tmr_ovf_en = 1'b1;
    @(negedge clk); tmr_ovf_evt = 1'b0;
    hold_asleep("R10 timer in power-down");
    tmr_ovf_en = 1'b0; tmr_cmp_en = 1'b0;
    recover();

    // Directed wakes
    run_case(2, 2, 3, 0, 0);
    run_case(3, 2, 0, 0, 0);
    run_case(3, 2, 4, 1, 1);
    run_case(2, 2, 1, 1, 0);
    run_case(3, 3, 2, 0, 1);
    run_case(3, 4, 0, 0, 1);
    run_case(3, 5, 2, 0, 1);
    run_case(2, 1, 5, 0, 0);
    run_case(3, 0, 1, 0, 0);

    // Constrained random wakes
    for (int i = 0; i < 40; i++) begin
      int mode, src, len, cancel, asy;
      mode = 2 + int'($urandom % 2);
      src = int'($urandom % 5);
      len = int'($urandom % 6);
      cancel = int'($urandom % 2);
      asy = int'($urandom % 2);
      if (src >= 3) begin mode = 3; asy = 1; end
      run_case(mode, src, len, cancel, asy);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule